// File: doc/BRIEF.md
# Multi-format stereo serial audio receiver

The block takes a three-wire serial audio stream (bit clock, frame clock, data) and turns it into parallel 24-bit left and right samples with a one-cycle strobe. The two serial clocks are not used as clocks. A faster system clock oversamples them through synchronizers, and each rising bit-clock edge becomes a single-cycle enable.

A static format pin selects one of two base framings. Low selects right-aligned 16-bit words. High selects the delayed left-aligned framing with words of up to 32 bits, cut down to 24. The block also measures how many bit clocks the frame clock spends high and low, and from that it recognises two more framings. A short sync pulse (at most 4 bit clocks high) selects a two-slot DSP framing. An exact 16/16 split with the format pin high selects packed 16-bit words. The detected framing is reported on a status output. A sticky flag reports frame-clock levels that are too short for the selected base framing.

Top module: `aud_ser_rx`

## Requirements
- R1: Data is sampled on rising bit-clock edges and arrives MSB first. A 16-bit word is output as `{word, 8'h00}`.
- R2: Right-aligned mode (`fmt_i`=0, not DSP): frame clock high is the left slot and low is the right slot. The word is the 16 bits sampled on the last 16 rising edges before the frame clock changes level.
- R3: Delayed mode (`fmt_i`=1): frame clock low is the left slot and high is the right slot. The MSB is the bit taken on the second rising edge of the slot, and 24 bits are taken from there.
- R4: In delayed mode, bits beyond the 24th are dropped. A word shorter than 24 bits, sent zero-padded, comes out with its padding unchanged.
- R5: With `fmt_i`=1 and a frame clock that stays high for exactly 16 and low for exactly 16 bit clocks, packed mode is used. Each slot carries a 16-bit word, with its MSB on the second rising edge of the slot.
- R6: A frame-clock high time of 4 bit clocks or fewer selects DSP mode. A left word of 16 bits and then a right word of 16 bits follow the rise of the pulse. The MSB is on the first rising edge after the pulse rises when `fmt_i`=1, and on the edge that first sees the pulse high when `fmt_i`=0.
- R7: `mode_o` encodes the framing as 0 right-aligned, 1 delayed, 2 packed, 3 DSP. It is re-decided on each frame-clock rise, once a full high and low period has been measured since reset.
- R8: `valid_o` is a one-cycle pulse per frame, issued after the right word completes. `left_o` and `right_o` change only together with it.
- R9: No pair is issued before the first mode decision. The first pair completed after a mode change is dropped.
- R10: `frame_err_o` sets when a complete frame-clock level is shorter than 16 bit clocks in right-aligned mode, or shorter than 24 in delayed mode. It stays set until reset.
- R11: During and after reset, `valid_o`, `left_o`, `right_o`, `mode_o` and `frame_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 1 | Static format select |
| bclk_i | input | 1 | Serial bit clock (oversampled) |
| lrclk_i | input | 1 | Serial frame clock (oversampled) |
| sdata_i | input | 1 | Serial data |
| left_o | output | 24 | Left sample |
| right_o | output | 24 | Right sample |
| valid_o | output | 1 | One-cycle pair strobe |
| mode_o | output | 2 | Detected framing code |
| frame_err_o | output | 1 | Sticky short-level flag |

## Verification
The bench targets these corner cases:
- **24-bit slots in delayed mode.** The LSB of a 24-bit word lands on the first edge of the next slot. A receiver that takes the word only inside its own slot loses that bit.
- **32-bit delayed words.** A design that takes the last 24 bits instead of the first would output the low-order bits.
- **Exact 16/16 framing and one-edge sync pulses.** A wrong detector would either misalign packed words by 8 bits or treat the pulse as a normal slot.
- **DSP delay variants.** Each `fmt_i` setting is run. A swapped variant shifts every sample by one bit.
- **Level lengths.** Right-aligned levels longer than 16 bit clocks are tested, because a design that counts from the slot start would pick up leading zeros. Short levels must raise the sticky error, and legal ones must leave it clear.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    MODE_RJ     = 2'd0,
    MODE_DLY    = 2'd1,
    MODE_PACKED = 2'd2,
    MODE_DSP    = 2'd3
  } rx_mode_e;

  localparam int unsigned MAX_W   = 32;
  localparam int unsigned OUT_W   = 24;
  localparam int unsigned SHORT_W = 16;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdata_i,
  output logic edge_o,
  output logic lr_o,
  output logic din_o
);
  logic [2:0] stg_q [STAGES];
  logic       bclk_d_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= {bclk_i, lrclk_i, sdata_i};
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_d_q <= 1'b0;
    else         bclk_d_q <= stg_q[STAGES-1][2];
  end

  assign edge_o = stg_q[STAGES-1][2] & ~bclk_d_q;
  assign lr_o   = stg_q[STAGES-1][1];
  assign din_o  = stg_q[STAGES-1][0];
endmodule

// File: rtl/aud_rx_meter.sv
module aud_rx_meter
  import aud_rx_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DSP_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             lr_i,
  input  logic             fmt_i,
  output logic             trans_o,
  output logic [CNT_W-1:0] lvl_cnt_o,
  output logic [2:0]       rise_cnt_o,
  output rx_mode_e         mode_o,
  output logic             mode_vld_o,
  output logic             mode_chg_o,
  output logic             frame_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lr_q, vld_q, err_q;
  logic [CNT_W-1:0] cnt_q, hi_len_q;
  logic [2:0]       rcnt_q;
  logic [1:0]       ntr_q;
  rx_mode_e         mode_q, mode_new;
  logic             decide, short_lvl;

  assign trans_o    = edge_i && (lr_i != lr_q);
  assign lvl_cnt_o  = trans_o ? CNT_W'(1) : (cnt_q == CNT_MAX ? cnt_q : cnt_q + 1'b1);
  assign rise_cnt_o = (trans_o && lr_i) ? 3'd1 : (rcnt_q == 3'd7 ? rcnt_q : rcnt_q + 3'd1);
  assign decide     = trans_o && lr_i && (ntr_q == 2'd2);

  always_comb begin
    if (hi_len_q <= CNT_W'(DSP_MAX))                                    mode_new = MODE_DSP;
    else if (fmt_i && hi_len_q == CNT_W'(16) && cnt_q == CNT_W'(16))    mode_new = MODE_PACKED;
    else if (fmt_i)                                                     mode_new = MODE_DLY;
    else                                                                mode_new = MODE_RJ;
  end

  assign mode_chg_o = decide && (!vld_q || mode_new != mode_q);
  assign short_lvl  = trans_o && ntr_q != 2'd0 && vld_q &&
                      ((mode_q == MODE_RJ  && cnt_q < CNT_W'(16)) ||
                       (mode_q == MODE_DLY && cnt_q < CNT_W'(24)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q <= 1'b0; cnt_q <= '0; rcnt_q <= 3'd7; hi_len_q <= '0;
      ntr_q <= '0; mode_q <= MODE_RJ; vld_q <= 1'b0; err_q <= 1'b0;
    end else if (edge_i) begin
      lr_q   <= lr_i;
      cnt_q  <= lvl_cnt_o;
      rcnt_q <= rise_cnt_o;
      if (trans_o) begin
        if (ntr_q != 2'd2) ntr_q <= ntr_q + 2'd1;
        if (lr_q) hi_len_q <= cnt_q;
      end
      if (decide) begin
        mode_q <= mode_new;
        vld_q  <= 1'b1;
      end
      if (short_lvl) err_q <= 1'b1;
    end
  end

  assign mode_o      = mode_q;
  assign mode_vld_o  = vld_q;
  assign frame_err_o = err_q;

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r7_mode_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(mode_q));
  a_r7_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> vld_q);
endmodule

// File: rtl/aud_rx_collect.sv
module aud_rx_collect
  import aud_rx_pkg::*;
#(
  parameter int unsigned W   = MAX_W,
  localparam int unsigned N_W = $clog2(W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           edge_i,
  input  logic           din_i,
  input  logic           start_i,
  input  logic [N_W-1:0] nbits_i,
  output logic           done_o,
  output logic [W-1:0]   word_o,
  output logic [W-1:0]   sr_o
);
  logic [W-1:0]   sr_q;
  logic [N_W-1:0] bitn_q, n_q;
  logic           act_q;

  assign done_o = edge_i && act_q && !start_i && (bitn_q == n_q - 1'b1);
  assign word_o = {sr_q[W-2:0], din_i};
  assign sr_o   = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; bitn_q <= '0; n_q <= '0; act_q <= 1'b0;
    end else if (edge_i) begin
      sr_q <= word_o;
      if (start_i) begin
        act_q  <= 1'b1;
        bitn_q <= N_W'(1);
        n_q    <= nbits_i;
      end else if (act_q) begin
        if (done_o) act_q  <= 1'b0;
        else        bitn_q <= bitn_q + 1'b1;
      end
    end
  end

  a_r1_done_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !act_q || $past(start_i));
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fmt_i,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  input  logic             sdata_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic [1:0]       mode_o,
  output logic             frame_err_o
);
  localparam int unsigned N_W = $clog2(MAX_W + 1);
  localparam int unsigned PAD = OUT_W - SHORT_W;

  logic             edge_s, lr_s, din_s, trans, mode_vld, mode_chg, done, start;
  logic [CNT_W-1:0] lvl_cnt;
  logic [2:0]       rise_cnt;
  rx_mode_e         mode;
  logic [N_W-1:0]   nbits;
  logic [MAX_W-1:0] word, sr;

  aud_rx_sync u_sync (
    .clk_i, .rst_ni, .bclk_i, .lrclk_i, .sdata_i,
    .edge_o(edge_s), .lr_o(lr_s), .din_o(din_s)
  );

  aud_rx_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i, .rst_ni, .edge_i(edge_s), .lr_i(lr_s), .fmt_i,
    .trans_o(trans), .lvl_cnt_o(lvl_cnt), .rise_cnt_o(rise_cnt),
    .mode_o(mode), .mode_vld_o(mode_vld), .mode_chg_o(mode_chg),
    .frame_err_o
  );

  always_comb begin
    start = 1'b0;
    nbits = N_W'(OUT_W);
    unique case (mode)
      MODE_DLY:    start = edge_s && lvl_cnt == CNT_W'(2);
      MODE_PACKED: begin start = edge_s && lvl_cnt == CNT_W'(2); nbits = N_W'(SHORT_W); end
      MODE_DSP:    begin start = edge_s && rise_cnt == (fmt_i ? 3'd2 : 3'd1); nbits = N_W'(MAX_W); end
      default:     ;
    endcase
  end

  aud_rx_collect #(.W(MAX_W)) u_coll (
    .clk_i, .rst_ni, .edge_i(edge_s), .din_i(din_s), .start_i(start),
    .nbits_i(nbits), .done_o(done), .word_o(word), .sr_o(sr)
  );

  logic             ch_r_q, skip_q;
  logic [OUT_W-1:0] left_q;
  logic             ld_left, pair;
  logic [OUT_W-1:0] w_cur, p_left, p_right;

  always_comb begin
    ld_left = 1'b0; pair = 1'b0;
    w_cur   = '0;   p_left = left_q; p_right = '0;
    if (mode == MODE_RJ) begin
      w_cur = {sr[SHORT_W-1:0], PAD'(0)};
      if (trans) begin
        // slot just ended was high (left) when the new level is low
        ld_left = !lr_s;
        pair    = lr_s;
        p_right = w_cur;
      end
    end else if (done) begin
      if (mode == MODE_DSP) begin
        pair    = 1'b1;
        p_left  = {word[2*SHORT_W-1:SHORT_W], PAD'(0)};
        p_right = {word[SHORT_W-1:0], PAD'(0)};
      end else begin
        w_cur   = (mode == MODE_PACKED) ? {word[SHORT_W-1:0], PAD'(0)} : word[OUT_W-1:0];
        ld_left = !ch_r_q;
        pair    = ch_r_q;
        p_right = w_cur;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_r_q <= 1'b0; skip_q <= 1'b0; left_q <= '0;
      left_o <= '0;   right_o <= '0;  valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start) ch_r_q <= lr_s;
      if (ld_left) left_q <= w_cur;
      if (mode_chg) skip_q <= 1'b1;
      else if (pair && mode_vld) skip_q <= 1'b0;
      if (pair && mode_vld && !skip_q && !mode_chg) begin
        left_o  <= p_left;
        right_o <= p_right;
        valid_o <= 1'b1;
      end
    end
  end

  assign mode_o = mode;

  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r8_hold_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(left_o));
  a_r8_hold_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(right_o));
endmodule

// File: tb/tb_aud_ser_rx.sv
module tb_aud_ser_rx;
  logic        clk = 1'b0, rst_n = 1'b0, fmt = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [23:0] left, right;
  logic        valid, ferr;
  logic [1:0]  mode;

  always #2.5 clk = ~clk;

  aud_ser_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .bclk_i(bclk), .lrclk_i(lrclk),
    .sdata_i(sdata), .left_o(left), .right_o(right), .valid_o(valid),
    .mode_o(mode), .frame_err_o(ferr)
  );

  int checks = 0, fails = 0;
  bit lr_s [0:511];
  bit d_s  [0:511];
  int n_s;
  logic [31:0] sl [0:7];
  logic [31:0] sr_v [0:7];
  int nf;
  logic [23:0] rl [0:63];
  logic [23:0] rr [0:63];
  int nr;

  always @(negedge clk) if (rst_n && valid && nr < 64) begin
    rl[nr] = left; rr[nr] = right; nr++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] top_mask(input int wl);
    return (wl >= 32) ? 32'hffff_ffff : ~(32'hffff_ffff >> wl);
  endfunction

  function automatic logic [23:0] exp24(input logic [31:0] v);
    return v[31:8];
  endfunction

  task automatic clear();
    for (int i = 0; i < 512; i++) begin lr_s[i] = 0; d_s[i] = 0; end
    n_s = 0; nf = 0; nr = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bclk = 0; lrclk = 0; sdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // delayed / packed framing: left on low level, MSB on second edge of slot
  task automatic add_dly(input int wl, input int lvl);
    logic [31:0] l = $urandom() & top_mask(wl);
    logic [31:0] r = $urandom() & top_mask(wl);
    int b = n_s;
    for (int p = 0; p < 2*lvl; p++) lr_s[b+p] = (p >= lvl);
    for (int k = 0; k < wl; k++) begin
      d_s[b+1+k]     = l[31-k];
      d_s[b+lvl+1+k] = r[31-k];
    end
    sl[nf] = l; sr_v[nf] = r; nf++; n_s += 2*lvl;
  endtask

  // right-aligned: left on high level, LSB on last edge of slot
  task automatic add_rj(input int lvl);
    logic [31:0] l = $urandom() & top_mask(16);
    logic [31:0] r = $urandom() & top_mask(16);
    int b = n_s;
    for (int p = 0; p < 2*lvl; p++) lr_s[b+p] = (p < lvl);
    for (int k = 0; k < 16; k++) begin
      d_s[b+lvl-16+k]   = l[31-k];
      d_s[b+2*lvl-16+k] = r[31-k];
    end
    sl[nf] = l; sr_v[nf] = r; nf++; n_s += 2*lvl;
  endtask

  task automatic add_dsp(input int pl, input int flen, input int dly);
    logic [31:0] l = $urandom() & top_mask(16);
    logic [31:0] r = $urandom() & top_mask(16);
    int b = n_s;
    for (int p = 0; p < flen; p++) lr_s[b+p] = (p < pl);
    for (int k = 0; k < 16; k++) begin
      d_s[b+dly+k]    = l[31-k];
      d_s[b+dly+16+k] = r[31-k];
    end
    sl[nf] = l; sr_v[nf] = r; nf++; n_s += flen;
  endtask

  task automatic play();
    bit tail = !lr_s[n_s-1];
    for (int i = 0; i < n_s + 2; i++) begin
      @(negedge clk);
      bclk = 0;
      lrclk = (i < n_s) ? lr_s[i] : tail;
      sdata = d_s[i];
      repeat (4) @(negedge clk);
      bclk = 1;
      repeat (3) @(negedge clk);
    end
    repeat (12) @(negedge clk);
  endtask

  // last three sent frames must appear consecutively among received pairs
  task automatic check_tail(input string req);
    int j = -1;
    for (int i = 0; i < nr; i++)
      if (j < 0 && rl[i] == exp24(sl[nf-3]) && rr[i] == exp24(sr_v[nf-3])) j = i;
    chk(j >= 0, req, (nr > 0) ? {8'h0, rl[0]} : 32'h0, {8'h0, exp24(sl[nf-3])});
    for (int f = 1; f < 3; f++) begin
      int idx = (j < 0) ? 0 : j + f;
      chk(j >= 0 && idx < nr && rl[idx] == exp24(sl[nf-3+f]), req,
          {8'h0, rl[idx]}, {8'h0, exp24(sl[nf-3+f])});
      chk(j >= 0 && idx < nr && rr[idx] == exp24(sr_v[nf-3+f]), req,
          {8'h0, rr[idx]}, {8'h0, exp24(sr_v[nf-3+f])});
    end
    chk(nr < nf, "R9 first frames dropped", nr, nf - 1);
  endtask

  task automatic run_ok(input int kind, input int a, input int b2, input bit f,
                        input logic [1:0] exp_mode, input string req);
    fmt = f;
    do_reset();
    clear();
    for (int i = 0; i < 6; i++) begin
      case (kind)
        0: add_dly(a, b2);
        1: add_rj(a);
        default: add_dsp(a, b2, f ? 1 : 0);
      endcase
    end
    play();
    check_tail(req);
    chk(mode == exp_mode, "R7 mode code", mode, exp_mode);
    chk(ferr == 1'b0, "R10 no error on legal levels", ferr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R11 reset state
    chk(valid == 0 && left == 0 && right == 0, "R11 reset outputs", {left[7:0], right[7:0], 7'b0, valid}, 0);
    chk(mode == 0 && ferr == 0, "R11 reset status", {ferr, mode}, 0);

    run_ok(0, 24, 24, 1, 2'd1, "R3 delayed 24/24");
    run_ok(0, 32, 32, 1, 2'd1, "R4 truncate 32-bit");
    run_ok(0, 20, 28, 1, 2'd1, "R4 short word padded");
    run_ok(0, 16, 16, 1, 2'd2, "R5 packed 16/16");
    run_ok(1, 16, 0, 0, 2'd0, "R2 right-aligned 16");
    run_ok(1, 21, 0, 0, 2'd0, "R2 R1 right-aligned long level");
    run_ok(2, 1, 40, 1, 2'd3, "R6 dsp delayed pulse1");
    run_ok(2, 4, 36, 0, 2'd3, "R6 dsp no-delay pulse4");
    run_ok(2, 3, 48, 1, 2'd3, "R6 dsp delayed pulse3");

    // R10: right-aligned levels of 12 edges
    fmt = 0; do_reset(); clear();
    for (int i = 0; i < 6; i++) add_rj(12);
    play();
    chk(ferr == 1'b1, "R10 short right-aligned level", ferr, 1);
    // R10: delayed levels of 20 edges, still set after more legal frames
    fmt = 1; do_reset(); clear();
    for (int i = 0; i < 6; i++) add_dly(16, 20);
    play();
    chk(ferr == 1'b1, "R10 short delayed level", ferr, 1);
    clear();
    for (int i = 0; i < 4; i++) add_dly(24, 24);
    play();
    chk(ferr == 1'b1, "R10 sticky", ferr, 1);

    // R9: mode change without reset, delayed -> DSP
    fmt = 1; do_reset(); clear();
    for (int i = 0; i < 4; i++) add_dly(24, 32);
    play();
    chk(mode == 2'd1, "R9 mode before change", mode, 1);
    clear();
    for (int i = 0; i < 6; i++) add_dsp(2, 40, 1);
    play();
    check_tail("R9 R6 after mode change");
    chk(mode == 2'd3, "R9 mode after change", mode, 3);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule